// File: doc/BRIEF.md
# Rotating-Top Register Stack File

This block is an eight-entry register file for a floating-point datapath whose entries are reached relative to a wrapping top-of-stack pointer rather than by absolute address. A producer issues one command per clock on an encoded opcode bus. The commands push a value, pop, write a result into any relative slot, write a result and then pop, swap the top with another slot, copy another slot into the top under a condition, step the pointer up or down, and reinitialise. Relative slot ST(i) always lives at physical entry (TOP + i) mod 8, so ST(0) is the top of the stack.

Two combinational read ports take relative indices and return entry contents in the same cycle. Every command that changes state does so on the rising clock edge. A tag bit per physical entry records whether it holds live data. Two one-cycle flags report a push onto a live entry (overflow) and a command that reads a dead entry (underflow). A command that raises a flag still executes in full. Arithmetic, format conversion and memory transfer belong to the surrounding datapath.

Top module: `rot_stack_file`

## Requirements
- R1: After a synchronous active-low reset, and in the cycle after an init command (opcode 9), TOP is 0 and every tag is clear. Init leaves entry data unchanged. Reset also zeroes the data.
- R2: Read port A (and likewise port B) combinationally returns physical entry (TOP + index) mod 8. Tag bit k of the tag output belongs to physical entry k.
- R3: Push (opcode 1) decrements TOP and then writes the write-data into the new ST(0) and sets its tag. The previous ST(0) becomes ST(1).
- R4: Pop (opcode 2) clears the tag of the current ST(0) and increments TOP. The previous ST(1) becomes ST(0), and no data changes.
- R5: Write (opcode 3) stores the write-data into ST(index) and sets its tag. TOP does not change.
- R6: Write-then-pop (opcode 4) stores the write-data into ST(i) and sets its tag, then clears the tag of the old ST(0) and increments TOP. Here i is the index input when the index-enable is high and 1 otherwise, so the default form leaves the result as the new ST(0). With i = 0 the clear wins and the written entry ends up untagged.
- R7: Exchange (opcode 5) swaps the data and tags of ST(0) and ST(i). The index i is chosen as in R6. With i = 0 nothing changes, and TOP never changes.
- R8: Conditional move (opcode 6) copies ST(index) into ST(0) and sets ST(0)'s tag only when the condition input is high. When the condition is low it changes nothing. TOP never changes.
- R9: Increment (opcode 7) and decrement (opcode 8) change TOP by +1 and -1 only. All data and tags stay in their physical entries.
- R10: The overflow flag is high for exactly the cycle after a push whose target entry (old ST(7)) was already tagged. The push still writes.
- R11: The underflow flag is high for exactly the cycle after one of these commands: a pop of an untagged ST(0), an exchange with either operand untagged, or a conditional move with its condition high and an untagged source. The command still executes.
- R12: All relative and pointer arithmetic wraps modulo 8. Decrementing from 0 gives 7, and incrementing from 7 gives 0. Opcode 0 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Command opcode, one per clock |
| idx_i | input | PTR_W | Relative index i for write, move and exchange |
| idx_en_i | input | 1 | High: use idx_i for exchange and write-then-pop; low: use 1 |
| cond_i | input | 1 | Condition for the conditional move |
| wr_data_i | input | DATA_W | Value for push, write and write-then-pop |
| rda_idx_i | input | PTR_W | Relative index of read port A |
| rda_data_o | output | DATA_W | Read port A data |
| rdb_idx_i | input | PTR_W | Relative index of read port B |
| rdb_data_o | output | DATA_W | Read port B data |
| top_o | output | PTR_W | Current top-of-stack pointer |
| tag_o | output | DEPTH | Live tag per physical entry |
| ovf_o | output | 1 | Overflow pulse, cycle after the push |
| unf_o | output | 1 | Underflow pulse, cycle after the command |

## Verification
The bench builds the block with DATA_W = 16 and the natural DEPTH = 8. The narrow data keeps the value patterns readable, while the full eight entries keep every pointer position and every relative index in play. After each command, both read ports sweep all eight relative slots in opposite orders, and the pointer, the tags and both flags are compared with an arithmetic model. Exchange, conditional move and write are each driven with every index from 0 to 7. The pointer is walked through both wrap points, and the stack is both overfilled and drained past empty.

// File: rtl/rsf_pkg.sv
// Package: shared command encoding for the rotating-top stack file.
// Assumes one command per clock on a 4-bit opcode bus.
package rsf_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_PUSH  = 4'd1,
        OP_POP   = 4'd2,
        OP_WRITE = 4'd3,
        OP_WRPOP = 4'd4,
        OP_XCHG  = 4'd5,
        OP_CMOV  = 4'd6,
        OP_INC   = 4'd7,
        OP_DEC   = 4'd8,
        OP_INIT  = 4'd9
    } rsf_op_e;

endpackage

// File: rtl/rsf_ptr.sv
// Module: top-of-stack pointer register.
// Holds TOP. It steps by +1 or -1 modulo 2**PTR_W, or returns to 0 on init.
// Assumes the caller never raises inc and dec together.
module rsf_ptr #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [PTR_W-1:0] top_o
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    logic [PTR_W-1:0] top_q;

    // Pointer update; natural wrap of the PTR_W-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)      top_q <= '0;
        else if (init_i) top_q <= '0;
        else if (inc_i)  top_q <= top_q + PTR_ONE;
        else if (dec_i)  top_q <= top_q - PTR_ONE;
    end

    assign top_o = top_q;
endmodule

// File: rtl/rsf_tags.sv
// Module: per-entry live tags.
// Sets one tag, clears one tag, or swaps two tags per cycle. A clear wins over
// a set on the same entry. Init clears all of them.
// Assumes swap is never combined with set or clear.
module rsf_tags #(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all_i,
    input  logic             set_en_i,
    input  logic [PTR_W-1:0] set_addr_i,
    input  logic             clr_en_i,
    input  logic [PTR_W-1:0] clr_addr_i,
    input  logic             swap_en_i,
    input  logic [PTR_W-1:0] swap_a_i,
    input  logic [PTR_W-1:0] swap_b_i,
    output logic [DEPTH-1:0] tag_o
);
    logic [DEPTH-1:0] tag_q;
    logic [DEPTH-1:0] tag_d;

    // Next-state tags from the one active tag operation.
    always_comb begin
        tag_d = tag_q;
        if (clr_all_i) begin
            tag_d = '0;
        end else if (swap_en_i) begin
            tag_d[swap_a_i] = tag_q[swap_b_i];
            tag_d[swap_b_i] = tag_q[swap_a_i];
        end else begin
            if (set_en_i) tag_d[set_addr_i] = 1'b1;
            if (clr_en_i) tag_d[clr_addr_i] = 1'b0;
        end
    end

    // Tag register.
    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign tag_o = tag_q;
endmodule

// File: rtl/rsf_store.sv
// Module: physical data array addressed by absolute entry number.
// Per cycle it performs at most one of: swap two entries, copy one entry into
// another, or write one external value. It has two combinational read ports.
// Assumes the controls are mutually exclusive.
module rsf_store #(
    parameter int DATA_W = 80,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              swap_en_i,
    input  logic [PTR_W-1:0]  swap_a_i,
    input  logic [PTR_W-1:0]  swap_b_i,
    input  logic              cpy_en_i,
    input  logic [PTR_W-1:0]  cpy_src_i,
    input  logic [PTR_W-1:0]  cpy_dst_i,
    input  logic [PTR_W-1:0]  rda_addr_i,
    output logic [DATA_W-1:0] rda_data_o,
    input  logic [PTR_W-1:0]  rdb_addr_i,
    output logic [DATA_W-1:0] rdb_data_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Entry update: each entry picks its own source for this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (swap_en_i && swap_a_i == PTR_W'(k))
                    mem[k] <= mem[swap_b_i];
                else if (swap_en_i && swap_b_i == PTR_W'(k))
                    mem[k] <= mem[swap_a_i];
                else if (cpy_en_i && cpy_dst_i == PTR_W'(k))
                    mem[k] <= mem[cpy_src_i];
                else if (wr_en_i && wr_addr_i == PTR_W'(k))
                    mem[k] <= wr_data_i;
            end
        end
    end

    // Combinational read ports.
    assign rda_data_o = mem[rda_addr_i];
    assign rdb_data_o = mem[rdb_addr_i];
endmodule

// File: rtl/rot_stack_file.sv
// Module: rotating-top register stack file (top level).
// Decodes one command per clock, maps relative indices to physical entries
// through TOP, and drives the pointer, tag and data sub-blocks. It registers
// the overflow and underflow pulses.
// Assumes DEPTH is a power of two so that pointer arithmetic wraps naturally.
module rot_stack_file
    import rsf_pkg::*;
#(
    parameter int DATA_W = 80,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [PTR_W-1:0]  idx_i,
    input  logic              idx_en_i,
    input  logic              cond_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rda_idx_i,
    output logic [DATA_W-1:0] rda_data_o,
    input  logic [PTR_W-1:0]  rdb_idx_i,
    output logic [DATA_W-1:0] rdb_data_o,
    output logic [PTR_W-1:0]  top_o,
    output logic [DEPTH-1:0]  tag_o,
    output logic              ovf_o,
    output logic              unf_o
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    rsf_op_e          op;
    logic [PTR_W-1:0] top;
    logic [DEPTH-1:0] tags;
    logic [PTR_W-1:0] eff_idx;
    logic [PTR_W-1:0] p_top, p_idx, p_new;
    logic             is_push, is_pop, is_wr, is_wrpop, is_xchg, is_cmov;
    logic             is_inc, is_dec, is_init;
    logic             wr_en, cpy_en;
    logic [PTR_W-1:0] wr_addr;
    logic             ovf_d, unf_d, ovf_q, unf_q;

    assign op = rsf_op_e'(op_i);

    // Command decode.
    always_comb begin
        is_push  = (op == OP_PUSH);
        is_pop   = (op == OP_POP);
        is_wr    = (op == OP_WRITE);
        is_wrpop = (op == OP_WRPOP);
        is_xchg  = (op == OP_XCHG);
        is_cmov  = (op == OP_CMOV);
        is_inc   = (op == OP_INC);
        is_dec   = (op == OP_DEC);
        is_init  = (op == OP_INIT);
    end

    // Relative-to-physical mapping; exchange and write-then-pop default to ST(1).
    always_comb begin
        eff_idx = ((is_xchg || is_wrpop) && !idx_en_i) ? PTR_ONE : idx_i;
        p_top   = top;
        p_idx   = top + eff_idx;
        p_new   = top - PTR_ONE;
    end

    // Data and tag control derived from the command.
    always_comb begin
        wr_en   = is_push || is_wr || is_wrpop;
        wr_addr = is_push ? p_new : p_idx;
        cpy_en  = is_cmov && cond_i;
    end

    // Error conditions seen before the edge that executes the command.
    always_comb begin
        ovf_d = is_push && tags[p_new];
        unf_d = (is_pop && !tags[p_top])
             || (is_xchg && (!tags[p_top] || !tags[p_idx]))
             || (cpy_en && !tags[p_idx]);
    end

    rsf_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (is_init),
        .inc_i  (is_pop || is_wrpop || is_inc),
        .dec_i  (is_push || is_dec),
        .top_o  (top)
    );

    rsf_tags #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_all_i  (is_init),
        .set_en_i   (wr_en || cpy_en),
        .set_addr_i (wr_en ? wr_addr : p_top),
        .clr_en_i   (is_pop || is_wrpop),
        .clr_addr_i (p_top),
        .swap_en_i  (is_xchg),
        .swap_a_i   (p_top),
        .swap_b_i   (p_idx),
        .tag_o      (tags)
    );

    rsf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data_i),
        .swap_en_i  (is_xchg),
        .swap_a_i   (p_top),
        .swap_b_i   (p_idx),
        .cpy_en_i   (cpy_en),
        .cpy_src_i  (p_idx),
        .cpy_dst_i  (p_top),
        .rda_addr_i (top + rda_idx_i),
        .rda_data_o (rda_data_o),
        .rdb_addr_i (top + rdb_idx_i),
        .rdb_data_o (rdb_data_o)
    );

    // One-cycle error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_d;
            unf_q <= unf_d;
        end
    end

    assign top_o = top;
    assign tag_o = tags;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;
endmodule

// File: rtl/rsf_checker.sv
// Module: temporal checks on the stack file's ports, bound into the top.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module rsf_checker
    import rsf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [PTR_W-1:0] top_o,
    input logic [DEPTH-1:0] tag_o,
    input logic             ovf_o,
    input logic             unf_o
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    a_r3_push_top: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_PUSH |=> top_o == $past(top_o) - ONE);
    a_r3_push_tag: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_PUSH |=> tag_o[top_o]);
    a_r4_pop_top: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_POP |=> top_o == $past(top_o) + ONE);
    a_r4_pop_tag: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_POP |=> !tag_o[$past(top_o)]);
    a_r8_cmov_top: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CMOV |=> $stable(top_o));
    a_r7_xchg_top: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_XCHG |=> $stable(top_o));
    a_r9_step_tags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC) |=> $stable(tag_o));
    a_r1_init: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_INIT |=> (top_o == '0 && tag_o == '0));
    a_r10_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        op_i != OP_PUSH |=> !ovf_o);
    a_r11_unf_source: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_POP && op_i != OP_XCHG && op_i != OP_CMOV) |=> !unf_o);
endmodule

bind rot_stack_file rsf_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .op_i  (op_i),
    .top_o (top_o),
    .tag_o (tag_o),
    .ovf_o (ovf_o),
    .unf_o (unf_o)
);

// File: tb/rot_stack_file_tb.sv
`timescale 1ns/1ps
module rot_stack_file_tb;
    localparam int DW = 16;
    localparam int DP = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    op_i = '0;
    logic [PW-1:0] idx_i = '0;
    logic          idx_en_i = 1'b0;
    logic          cond_i = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic [PW-1:0] rda_idx_i = '0;
    logic [PW-1:0] rdb_idx_i = '0;
    logic [DW-1:0] rda_data_o, rdb_data_o;
    logic [PW-1:0] top_o;
    logic [DP-1:0] tag_o;
    logic          ovf_o, unf_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state
    logic [DW-1:0] mdl [DP];
    bit   [DP-1:0] mtag;
    int            mtop;
    bit            e_ovf, e_unf;

    always #5 clk = ~clk;

    rot_stack_file #(.DATA_W(DW), .DEPTH(DP)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i),
        .idx_en_i(idx_en_i), .cond_i(cond_i), .wr_data_i(wr_data_i),
        .rda_idx_i(rda_idx_i), .rda_data_o(rda_data_o),
        .rdb_idx_i(rdb_idx_i), .rdb_data_o(rdb_data_o),
        .top_o(top_o), .tag_o(tag_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every visible output against the model.
    task automatic verify(string req);
        chk(req, "top", top_o, mtop);
        chk(req, "tags", tag_o, mtag);
        chk({req, " R10"}, "ovf", ovf_o, e_ovf);
        chk({req, " R11"}, "unf", unf_o, e_unf);
        for (int i = 0; i < DP; i++) begin
            rda_idx_i = PW'(i);
            rdb_idx_i = PW'(DP - 1 - i);
            #0.2;
            chk("R2", "port A", rda_data_o, mdl[(mtop + i) % DP]);
            chk("R2", "port B", rdb_data_o, mdl[(mtop + DP - 1 - i) % DP]);
        end
    endtask

    task automatic run_op(int o, int ix, bit ie, bit c, logic [DW-1:0] d, string req);
        int ei, p;
        logic [DW-1:0] tv;
        bit tt;
        ei = ((o == 5 || o == 4) && !ie) ? 1 : ix;
        p  = (mtop + ei) % DP;
        e_ovf = (o == 1) && mtag[(mtop + DP - 1) % DP];
        e_unf = (o == 2 && !mtag[mtop])
             || (o == 5 && (!mtag[mtop] || !mtag[p]))
             || (o == 6 && c && !mtag[p]);
        case (o)
            1: begin mtop = (mtop + DP - 1) % DP; mdl[mtop] = d; mtag[mtop] = 1'b1; end
            2: begin mtag[mtop] = 1'b0; mtop = (mtop + 1) % DP; end
            3: begin mdl[p] = d; mtag[p] = 1'b1; end
            4: begin mdl[p] = d; mtag[p] = 1'b1; mtag[mtop] = 1'b0; mtop = (mtop + 1) % DP; end
            5: begin
                tv = mdl[mtop]; mdl[mtop] = mdl[p]; mdl[p] = tv;
                tt = mtag[mtop]; mtag[mtop] = mtag[p]; mtag[p] = tt;
            end
            6: if (c) begin mdl[mtop] = mdl[p]; mtag[mtop] = 1'b1; end
            7: mtop = (mtop + 1) % DP;
            8: mtop = (mtop + DP - 1) % DP;
            9: begin mtop = 0; mtag = '0; end
            default: ;
        endcase
        @(negedge clk);
        op_i = 4'(o); idx_i = PW'(ix); idx_en_i = ie; cond_i = c; wr_data_i = d;
        @(posedge clk);
        #1 op_i = '0;
        @(negedge clk);
        verify(req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < DP; k++) mdl[k] = '0;
        mtag = '0; mtop = 0; e_ovf = 0; e_unf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        verify("R1");

        // Fill the stack; the pointer wraps below 0 on the first push.
        for (int k = 0; k < DP; k++) run_op(1, 0, 0, 0, DW'(16'h1000 + k * 16'h0111), "R3 R12");
        run_op(1, 0, 0, 0, 16'hBEEF, "R10");

        // Exchange every index, then the default form.
        for (int i = 0; i < DP; i++) run_op(5, i, 1, 0, '0, "R7");
        run_op(5, 5, 0, 0, '0, "R7");

        // Conditional move with both condition values.
        for (int i = 0; i < DP; i++) run_op(6, i, 0, i[0], '0, "R8");

        // Write into every relative slot.
        for (int i = 0; i < DP; i++) run_op(3, i, 0, 0, DW'(16'hA000 + i), "R5");

        // Pointer stepping through both wrap points.
        for (int i = 0; i < DP + 1; i++) run_op(7, 0, 0, 0, '0, "R9 R12");
        for (int i = 0; i < 3; i++) run_op(8, 0, 0, 0, '0, "R9 R12");

        // Write-then-pop: default, indexed, and index 0.
        run_op(4, 6, 0, 0, 16'h5151, "R6");
        run_op(4, 2, 1, 0, 16'h5252, "R6");
        run_op(4, 0, 1, 0, 16'h5353, "R6");

        // Drain past empty.
        for (int i = 0; i < DP + 2; i++) run_op(2, 0, 0, 0, '0, "R4 R11");

        // Reads of dead entries.
        run_op(5, 3, 1, 0, '0, "R11");
        run_op(6, 2, 0, 1, '0, "R11");
        run_op(6, 2, 0, 0, '0, "R11");

        // Init after some pushes, then reuse.
        run_op(1, 0, 0, 0, 16'h7001, "R3");
        run_op(1, 0, 0, 0, 16'h7002, "R3");
        run_op(9, 0, 0, 0, '0, "R1");
        run_op(1, 0, 0, 0, 16'h7003, "R3");
        run_op(0, 0, 0, 0, '0, "R12");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule